// File: doc/BRIEF.md
# Endpoint Interrupt Mask and Status Unit

This block collects interrupt events from sixteen device-side endpoints and latches each one in a status bit. Each endpoint also has a mask bit. The mask decides whether a new event may set that endpoint's status bit at all. It does not gate the output. A status bit that is already set therefore stays set and visible when its mask is raised later. Software clears a status bit by writing 1 to it.

The endpoints fall into two groups of eight. Each group has one mask register and one status register, and all four are reached through a small synchronous register port. Writes take effect at the clock edge. Read data is a combinational decode of the current address.

A single interrupt request leaves the block. It is the registered OR of every status bit.

Endpoint 0 carries control traffic. Endpoints 1, 3, 5 and 6 report transmit events, and endpoints 2, 4 and 7 report receive events. The masking and latching rules are identical for every endpoint.

Top module: `ep_irq_gate`

## Requirements
- R1: After reset, both mask registers read 0x000000FF, both status registers read 0, and `irq_o` is 0.
- R2: While an endpoint's mask bit is 1, an event pulse on that endpoint leaves its status bit at 0. The mask for endpoint n (n<8) is bit n at offset 0x0. The mask for endpoint 8+n is bit n at offset 0x4.
- R3: While an endpoint's mask bit is 0, an event pulse sets its status bit at the next clock edge. The status for endpoint n is bit n at offset 0x8. The status for endpoint 8+n is bit n at offset 0xC.
- R4: Writing a mask bit to 1 leaves that endpoint's status bit unchanged.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: If a clear and an unmasked event hit the same bit in the same cycle, the bit stays set.
- R7: `irq_o` goes to 1 one cycle after any status bit is 1. It returns to 0 one cycle after all status bits are 0.
- R8: Bits 31:8 of every register read as 0, and writes to them are ignored. Reads of any offset other than 0x0, 0x4, 0x8 or 0xC return 0, and writes to such offsets change nothing.
- R9: An event in the same cycle as a write to its mask register is gated by the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 16 | One-cycle event pulse per endpoint, bit n for endpoint n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two pairs of operations can land in the same cycle.

- **Event and status clear:** a write of 1 to a status bit can coincide with an unmasked event on that bit. The bench drives every event line together with an all-ones clear, and it passes only if the status still reads all ones at the next read.
- **Event and mask write:** a mask write can coincide with an event on the endpoint it governs. The bench pulses the event while the mask changes in each direction. The status readback must follow the mask value held before the write.

// File: rtl/ep_irq_gate.sv
module ep_irq_gate #(
  parameter int GRP_W  = 8,
  parameter int NGRP   = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(NGRP * 8)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GRP_W*NGRP-1:0]   ev_i,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irq_o
);
  localparam int NEP = GRP_W * NGRP;

  logic [NEP-1:0] mask_q, stat_q, clr, set_ok;
  logic           unused_wd;

  assign unused_wd = ^wdata[DATA_W-1:GRP_W];
  assign set_ok    = ev_i & ~mask_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] MOFF = ADDR_W'(g * 4);
    localparam logic [ADDR_W-1:0] SOFF = ADDR_W'((NGRP + g) * 4);

    assign clr[g*GRP_W +: GRP_W] = (wr_en && addr == SOFF) ? wdata[GRP_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        mask_q[g*GRP_W +: GRP_W] <= '1;
      else if (wr_en && addr == MOFF)
        mask_q[g*GRP_W +: GRP_W] <= wdata[GRP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | set_ok;
      irq_o  <= |stat_q;
    end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (addr == ADDR_W'(g * 4))
        rdata[GRP_W-1:0] = mask_q[g*GRP_W +: GRP_W];
      if (addr == ADDR_W'((NGRP + g) * 4))
        rdata[GRP_W-1:0] = stat_q[g*GRP_W +: GRP_W];
    end
  end

  for (genvar i = 0; i < NEP; i++) begin : g_chk
    AST_MASK_BLOCKS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[i]) |-> $past(ev_i[i] && !mask_q[i])); // R2
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[i] && !mask_q[i]) |=> stat_q[i]); // R3
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr[i]) |=> stat_q[i]); // R4
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !(ev_i[i] && !mask_q[i])) |=> !stat_q[i]); // R5
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|stat_q) |=> !irq_o); // R7
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:GRP_W] == '0); // R8
endmodule

// File: tb/ep_irq_gate_tb_top.sv
`timescale 1ns/1ps
module ep_irq_gate_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [15:0] ev_i = 0;
  logic        wr_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq_o;

  int nvec = 0, nbad = 0;
  logic [15:0] mk = 16'hFFFF, st = 16'h0;
  logic        irq_m = 0;

  always #2.5 clk = ~clk;

  ep_irq_gate dut_i (.clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0: return {24'h0, mk[7:0]};
      4'h4: return {24'h0, mk[15:8]};
      4'h8: return {24'h0, st[7:0]};
      4'hC: return {24'h0, st[15:8]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [3:0] a, input string tag);
    wr_en = 0; addr = a; #0.5;
    check(rdata, exp_rd(a), tag);
  endtask

  task automatic step(input logic [15:0] ev, input bit we, input logic [3:0] a,
                      input logic [31:0] d);
    logic [15:0] clr;
    @(negedge clk);
    ev_i = ev; wr_en = we; addr = a; wdata = d;
    @(posedge clk); #1;
    clr = (we && a == 4'h8) ? {8'h0, d[7:0]} : (we && a == 4'hC) ? {d[7:0], 8'h0} : 16'h0;
    irq_m = |st;
    st = (st & ~clr) | (ev & ~mk);
    if (we && a == 4'h0) mk[7:0] = d[7:0];
    if (we && a == 4'h4) mk[15:8] = d[7:0];
    ev_i = 0; wr_en = 0;
    check({31'h0, irq_o}, {31'h0, irq_m}, "R7 irq");
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    check({31'h0, irq_o}, 32'h0, "R1 irq");
    rd(4'h0, "R1 mask0"); rd(4'h4, "R1 mask1");
    rd(4'h8, "R1 stat0"); rd(4'hC, "R1 stat1");

    for (int ep = 0; ep < 16; ep++) begin
      for (int m = 0; m < 2; m++) begin
        logic [3:0] moff, soff;
        logic [7:0] bit1;
        moff = (ep < 8) ? 4'h0 : 4'h4;
        soff = (ep < 8) ? 4'h8 : 4'hC;
        bit1 = 8'h1 << (ep % 8);
        step(0, 1, moff, m ? 32'hFF : {24'h0, ~bit1});
        step(16'h1 << ep, 0, 0, 0);
        rd(soff, m ? "R2 masked event" : "R3 unmasked event");
        rd(4'h8, "R3 group0"); rd(4'hC, "R3 group1");
        step(0, 0, 0, 0);
        step(0, 1, moff, 32'hFF);
        rd(soff, "R4 mask keeps status");
        step(0, 1, soff, {24'h0, ~bit1});
        rd(soff, "R5 write zero keeps");
        step(0, 1, soff, {24'h0, bit1});
        rd(soff, "R5 write one clears");
        step(0, 0, 0, 0);
      end
    end

    step(0, 1, 4'h0, 0); step(0, 1, 4'h4, 0);
    step(16'hFFFF, 0, 0, 0);
    step(16'hFFFF, 1, 4'h8, 32'hFF);
    rd(4'h8, "R6 clear vs event");
    step(16'hFFFF, 1, 4'hC, 32'hFF);
    rd(4'hC, "R6 clear vs event");
    step(0, 1, 4'h8, 32'hFF); step(0, 1, 4'hC, 32'hFF);
    rd(4'h8, "R5 clear all"); step(0, 0, 0, 0);

    step(0, 1, 4'h0, 32'hFF);
    step(16'h0001, 1, 4'h0, 32'h00);
    rd(4'h8, "R9 old mask blocks");
    step(16'h0002, 1, 4'h0, 32'hFF);
    rd(4'h8, "R9 old mask passes");
    step(0, 1, 4'h8, 32'hFF);

    step(0, 1, 4'h4, 32'hFFFF_FF5A);
    rd(4'h4, "R8 reserved write");
    for (int a = 0; a < 16; a++)
      if (a % 4 != 0) step(0, 1, 4'(a), 32'h0);
    for (int a = 0; a < 16; a++) rd(4'(a), "R8 decode");

    r = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      step(r[15:0], r[16], {r[19:18], r[22] ? r[21:20] : 2'b00}, {r[31:24], r[31:24], r[7:0], r[30:23]});
      rd({r[27:26], 2'b00}, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule